// File: doc/BRIEF.md
# Unaligned Bit-Stream Copy Engine

This engine moves a run of bits from a source byte memory into a destination byte memory. Three values set up a transfer: a source bit offset, a destination bit offset and a bit count. None of them has to be a multiple of eight. The engine streams the source bytes through a shift accumulator and writes destination bytes one at a time. Destination bits that lie outside the copied run keep their old values. To achieve this, the engine reads the first and last destination bytes and merges the new bits into them.

Both memories have synchronous read ports with one cycle of latency. The destination also has a write port. A transfer starts with a single-cycle `start` and ends with a single-cycle `done`. Each cycle the engine issues at most one source read and one destination write. This gives a throughput of one byte per cycle for any bit phase. The source and destination regions must not overlap.

Top module: `bitcopy_engine`

## Requirements
- R1: A bit offset `o` names byte `o>>3`, bit `o&7`, with bit 0 as the least significant bit of a byte. Source bit `s+i` lands at destination bit `d+i` for every `i` below the count.
- R2: The copy is correct for every combination of source bit phase, destination bit phase and count, including counts that span one byte or many bytes.
- R3: In the first destination byte, the bits below the destination bit position keep their previous values.
- R4: In the last destination byte, the bits at and above the end position keep their previous values. No byte outside the range from `d>>3` to `(d+n-1)>>3` is written.
- R5: With a count of zero, `done` rises one cycle after `start`, and no destination read or write takes place.
- R6: When both offsets are multiples of eight, no destination read occurs before the body. Each full byte is written as the unchanged source byte, and only a partial final byte is read and merged.
- R7: At most one destination write occurs per cycle. For an aligned transfer, full bytes are written on consecutive cycles. At most seven pending bits stay in the accumulator between steps.
- R8: After reset, `busy` and `done` are low. `busy` is high from the cycle after an accepted start. `done` is a single-cycle pulse in the cycle after the final destination write.
- R9: A `start` that arrives while `busy` is high is ignored: no other region is touched and only one `done` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| src_bit_off | input | ADDR_W+3 | Source start bit offset |
| dst_bit_off | input | ADDR_W+3 | Destination start bit offset |
| bit_count | input | ADDR_W+4 | Number of bits to copy |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | ADDR_W | Source byte address |
| src_rd_data | input | 8 | Source byte, valid one cycle after the request |
| dst_rd_en | output | 1 | Destination read request (boundary bytes) |
| dst_rd_addr | output | ADDR_W | Destination read byte address |
| dst_rd_data | input | 8 | Destination byte, valid one cycle after the request |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | ADDR_W | Destination write byte address |
| dst_wr_data | output | 8 | Destination write byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Source data returns one cycle after each read request, so a destination write lags its source read by one cycle. When the destination bit phase is nonzero, a two-cycle boundary read comes first. `done` is due exactly one cycle after the last write. For a zero count, `done` is due one cycle after the start edge. The bench drives and samples on the falling edge and stamps every write and `done` with a cycle number. It then compares those stamps: for example, `done` must equal the last write plus one, and aligned writes must be back to back. The final memory contents are compared against a bit-by-bit model that is built only from the offset rule.

// File: rtl/bitcopy_pkg.sv
package bitcopy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD_RD,
        ST_HEAD_CAP,
        ST_STREAM,
        ST_TAIL_RD,
        ST_TAIL_WR
    } bc_state_e;
endpackage

// File: rtl/bitcopy_fetch.sv
module bitcopy_fetch #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_byte,
    input  logic [2:0]        load_bit,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              en,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    output logic              arr_vld,
    output logic [2:0]        arr_shift,
    output logic [3:0]        arr_take,
    output logic              all_issued
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [2:0]        shift;
        logic              pv;
        logic [2:0]        pshift;
        logic [3:0]        ptake;
    } fetch_t;

    fetch_t q, d;
    logic [3:0] room;
    logic [3:0] take;
    logic       issue;

    always_comb begin
        room  = 4'd8 - {1'b0, q.shift};
        take  = (q.left < CNT_W'(room)) ? q.left[3:0] : room;
        issue = en && (q.left != '0);
        d     = q;
        d.pv  = issue;
        if (issue) begin
            d.pshift = q.shift;
            d.ptake  = take;
            d.addr   = q.addr + 1'b1;
            d.left   = q.left - CNT_W'(take);
            d.shift  = 3'd0;
        end
        if (load) begin
            d.addr  = load_byte;
            d.left  = load_cnt;
            d.shift = load_bit;
            d.pv    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_rd_en   = issue;
    assign src_rd_addr = q.addr;
    assign arr_vld     = q.pv;
    assign arr_shift   = q.pshift;
    assign arr_take    = q.ptake;
    assign all_issued  = (q.left == '0);

    // R2: every arriving slice carries at least one bit and stays inside its byte
    a_r2_slice_fits: assert property (@(posedge clk) disable iff (!rst_n)
        arr_vld |-> (arr_take != 4'd0) && (({2'b00, arr_shift} + {1'b0, arr_take}) <= 5'd8));
endmodule

// File: rtl/bitcopy_pack.sv
module bitcopy_pack #(
    parameter int ACC_W = 16,
    localparam int CW   = $clog2(ACC_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [7:0]    init_bits,
    input  logic [2:0]    init_cnt,
    input  logic          aligned,
    input  logic          arr_vld,
    input  logic [7:0]    arr_data,
    input  logic [2:0]    arr_shift,
    input  logic [3:0]    arr_take,
    output logic          wr_fire,
    output logic [7:0]    wr_byte,
    output logic [CW-1:0] cnt_next,
    output logic [7:0]    acc_low,
    output logic [CW-1:0] acc_cnt
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CW-1:0]    cnt;
    } pack_t;

    pack_t q, d;
    logic [7:0]       shifted;
    logic [7:0]       tmask;
    logic [7:0]       bits;
    logic [ACC_W-1:0] merged;
    logic [CW-1:0]    total;

    always_comb begin
        shifted = arr_data >> arr_shift;
        tmask   = 8'hFF >> (4'd8 - arr_take);
        bits    = shifted & tmask;
        merged  = q.acc | (ACC_W'(bits) << q.cnt);
        total   = q.cnt + CW'(arr_take);
        wr_fire = arr_vld && (total >= CW'(8));
        d       = q;
        if (arr_vld) begin
            if (wr_fire) begin
                d.acc = merged >> 8;
                d.cnt = total - CW'(8);
            end else begin
                d.acc = merged;
                d.cnt = total;
            end
        end
        if (init) begin
            d.acc = ACC_W'(init_bits & ~(8'hFF << init_cnt));
            d.cnt = CW'(init_cnt);
        end
        wr_byte = aligned ? arr_data : merged[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_next = d.cnt;
    assign acc_low  = q.acc[7:0];
    assign acc_cnt  = q.cnt;

    // R7: never more than seven bits wait in the accumulator
    a_r7_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= CW'(7));

    // R6: the aligned bypass and the accumulator path agree on every full byte
    a_r6_aligned_path: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && wr_fire) |-> (merged[7:0] == arr_data));
endmodule

// File: rtl/bitcopy_engine.sv
module bitcopy_engine
    import bitcopy_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ACC_W  = 16,
    localparam int OFF_W = ADDR_W + 3,
    localparam int CNT_W = ADDR_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  src_bit_off,
    input  logic [OFF_W-1:0]  dst_bit_off,
    input  logic [CNT_W-1:0]  bit_count,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [7:0]        src_rd_data,
    output logic              dst_rd_en,
    output logic [ADDR_W-1:0] dst_rd_addr,
    input  logic [7:0]        dst_rd_data,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic [7:0]        dst_wr_data,
    output logic              busy,
    output logic              done
);
    localparam int CW = $clog2(ACC_W + 1);

    typedef struct packed {
        bc_state_e         state;
        logic [ADDR_W-1:0] wr_addr;
        logic [2:0]        dbit;
        logic              aligned;
        logic              done;
    } top_t;

    top_t q, d;

    logic          fetch_load;
    logic          fetch_en;
    logic          arr_vld;
    logic [2:0]    arr_shift;
    logic [3:0]    arr_take;
    logic          all_issued;
    logic          pack_init;
    logic [7:0]    init_bits;
    logic [2:0]    init_cnt;
    logic          wr_fire;
    logic [7:0]    wr_byte;
    logic [CW-1:0] cnt_next;
    logic [7:0]    acc_low;
    logic [CW-1:0] acc_cnt;
    logic [7:0]    keep;
    logic [7:0]    tail_byte;

    bitcopy_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fetch_load),
        .load_byte  (src_bit_off[OFF_W-1:3]),
        .load_bit   (src_bit_off[2:0]),
        .load_cnt   (bit_count),
        .en         (fetch_en),
        .src_rd_en  (src_rd_en),
        .src_rd_addr(src_rd_addr),
        .arr_vld    (arr_vld),
        .arr_shift  (arr_shift),
        .arr_take   (arr_take),
        .all_issued (all_issued)
    );

    bitcopy_pack #(.ACC_W(ACC_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (pack_init),
        .init_bits(init_bits),
        .init_cnt (init_cnt),
        .aligned  (q.aligned),
        .arr_vld  (arr_vld),
        .arr_data (src_rd_data),
        .arr_shift(arr_shift),
        .arr_take (arr_take),
        .wr_fire  (wr_fire),
        .wr_byte  (wr_byte),
        .cnt_next (cnt_next),
        .acc_low  (acc_low),
        .acc_cnt  (acc_cnt)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        fetch_load = 1'b0;
        pack_init  = 1'b0;
        init_bits  = 8'h00;
        init_cnt   = 3'd0;
        fetch_en   = (q.state == ST_STREAM);
        keep       = 8'hFF << acc_cnt;
        tail_byte  = (acc_low & ~keep) | (dst_rd_data & keep);
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (bit_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        fetch_load = 1'b1;
                        pack_init  = 1'b1;
                        d.wr_addr  = dst_bit_off[OFF_W-1:3];
                        d.dbit     = dst_bit_off[2:0];
                        d.aligned  = (src_bit_off[2:0] == 3'd0) && (dst_bit_off[2:0] == 3'd0);
                        d.state    = (dst_bit_off[2:0] != 3'd0) ? ST_HEAD_RD : ST_STREAM;
                    end
                end
            end
            ST_HEAD_RD:  d.state = ST_HEAD_CAP;
            ST_HEAD_CAP: begin
                pack_init = 1'b1;
                init_bits = dst_rd_data;
                init_cnt  = q.dbit;
                d.state   = ST_STREAM;
            end
            ST_STREAM: begin
                if (wr_fire) d.wr_addr = q.wr_addr + 1'b1;
                if (all_issued && arr_vld) begin
                    if (cnt_next == '0) begin
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_TAIL_RD;
                    end
                end
            end
            ST_TAIL_RD: d.state = ST_TAIL_WR;
            ST_TAIL_WR: begin
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign dst_rd_en   = (q.state == ST_HEAD_RD) || (q.state == ST_TAIL_RD);
    assign dst_rd_addr = q.wr_addr;
    assign dst_wr_en   = ((q.state == ST_STREAM) && wr_fire) || (q.state == ST_TAIL_WR);
    assign dst_wr_addr = q.wr_addr;
    assign dst_wr_data = (q.state == ST_TAIL_WR) ? tail_byte : wr_byte;
    assign busy        = (q.state != ST_IDLE);
    assign done        = q.done;

    // R5: an empty transfer finishes at once without writing
    a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bit_count == '0) |=> (done && !busy && !dst_wr_en));

    // R8: done lasts a single cycle and leaves the engine idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: destination writes happen only inside an accepted transfer
    a_r4_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> busy);

    // R7: the destination port never reads and writes in one cycle
    a_r7_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(dst_rd_en && dst_wr_en));

    // R9: a start during a transfer does not restart it
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !dst_rd_en) |=> (busy || done));
endmodule

// File: tb/sim_bitcopy_engine.sv
`timescale 1ns/1ps
module sim_bitcopy_engine;
    localparam int ADDR_W = 8;
    localparam int OFF_W  = ADDR_W + 3;
    localparam int CNT_W  = ADDR_W + 4;
    localparam int MEM_N  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [OFF_W-1:0] src_bit_off = '0;
    logic [OFF_W-1:0] dst_bit_off = '0;
    logic [CNT_W-1:0] bit_count = '0;
    logic src_rd_en, dst_rd_en, dst_wr_en, busy, done;
    logic [ADDR_W-1:0] src_rd_addr, dst_rd_addr, dst_wr_addr;
    logic [7:0] src_rd_data, dst_rd_data, dst_wr_data;

    logic [7:0] smem [MEM_N];
    logic [7:0] dmem [MEM_N];
    logic [7:0] expm [MEM_N];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seed = 0;
    int nwr, nrd, ndone, first_wr, last_wr, done_cyc, bad_wr, lo_b, hi_b;

    always #2 clk = ~clk;

    bitcopy_engine #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_bit_off(src_bit_off), .dst_bit_off(dst_bit_off), .bit_count(bit_count),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .dst_rd_en(dst_rd_en), .dst_rd_addr(dst_rd_addr), .dst_rd_data(dst_rd_data),
        .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_rd_en) src_rd_data <= smem[src_rd_addr];
        if (dst_rd_en) dst_rd_data <= dmem[dst_rd_addr];
        if (dst_wr_en) dmem[dst_wr_addr] <= dst_wr_data;
    end

    always @(negedge clk) begin
        if (dst_wr_en) begin
            if (nwr == 0) first_wr = cyc;
            last_wr = cyc;
            nwr++;
            if (int'(dst_wr_addr) < lo_b || int'(dst_wr_addr) > hi_b) bad_wr++;
        end
        if (dst_rd_en) nrd++;
        if (done) begin
            ndone++;
            done_cyc = cyc;
        end
    end

    function automatic logic [7:0] src_pat(int i);
        return 8'((i * 37 + 11) ^ seed);
    endfunction

    function automatic logic [7:0] dst_pat(int i);
        return 8'((i * 91 + 5) ^ (seed * 3));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_and_model(int s, int d, int n);
        logic [7:0] b;
        for (int i = 0; i < MEM_N; i++) begin
            smem[i] <= src_pat(i);
            dmem[i] <= dst_pat(i);
            expm[i] = dst_pat(i);
        end
        // R1: source bit s+k goes to destination bit d+k, LSB-first in each byte
        for (int k = 0; k < n; k++) begin
            b = src_pat((s + k) >> 3);
            expm[(d + k) >> 3][(d + k) & 7] = b[(s + k) & 7];
        end
    endtask

    task automatic clear_mon(int lo, int hi);
        nwr = 0; nrd = 0; ndone = 0; bad_wr = 0;
        first_wr = -1; last_wr = -1; done_cyc = -1;
        lo_b = lo; hi_b = hi;
    endtask

    task automatic wait_done(string req);
        int waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 3000) check(1'b0, req, "watchdog expired waiting for done", waited, 0);
        @(negedge clk);
    endtask

    task automatic run_copy(int s, int d, int n, bit poke, string req);
        int mism = 0;
        logic [7:0] m;
        fill_and_model(s, d, n);
        @(negedge clk);
        clear_mon(d >> 3, (d + n - 1) >> 3);
        src_bit_off = OFF_W'(s);
        dst_bit_off = OFF_W'(d);
        bit_count   = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after accepted start", busy, 1);
        if (poke) begin
            @(negedge clk);
            src_bit_off = OFF_W'(0);
            dst_bit_off = OFF_W'(1400);
            bit_count   = CNT_W'(50);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(req);
        repeat (20) @(negedge clk);
        for (int i = 0; i < MEM_N; i++) if (dmem[i] !== expm[i]) mism++;
        check(mism == 0, req, "destination bytes differing from model", mism, 0);
        check(bad_wr == 0, "R4", "writes outside the target byte range", bad_wr, 0);
        check(done_cyc == last_wr + 1, "R8", "done cycle vs last write", done_cyc, last_wr + 1);
        check(ndone == 1, "R8", "done pulses per transfer", ndone, 1);
        m = 8'hFF >> (8 - (d & 7));
        check((dmem[d >> 3] & m) == (dst_pat(d >> 3) & m), "R3",
              "kept low bits of first byte", int'(dmem[d >> 3] & m), int'(dst_pat(d >> 3) & m));
        m = 8'hFF << ((d + n) & 7);
        if (((d + n) & 7) != 0)
            check((dmem[(d + n) >> 3] & m) == (dst_pat((d + n) >> 3) & m), "R4",
                  "kept high bits of last byte", int'(dmem[(d + n) >> 3] & m),
                  int'(dst_pat((d + n) >> 3) & m));
    endtask

    task automatic test_reset;
        check(busy == 1'b0, "R8", "busy after reset", busy, 0);
        check(done == 1'b0, "R8", "done after reset", done, 0);
        check(dst_wr_en == 1'b0, "R8", "write strobe after reset", dst_wr_en, 0);
    endtask

    task automatic test_zero_count;
        seed = 9;
        fill_and_model(12, 30, 0);
        @(negedge clk);
        clear_mon(0, -1);
        src_bit_off = OFF_W'(12);
        dst_bit_off = OFF_W'(30);
        bit_count   = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R5", "done one cycle after zero-count start", done, 1);
        check(busy == 1'b0, "R5", "busy during zero-count transfer", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", done, 0);
        repeat (4) @(negedge clk);
        check(nwr == 0, "R5", "writes for zero count", nwr, 0);
        check(nrd == 0, "R5", "destination reads for zero count", nrd, 0);
    endtask

    task automatic test_aligned;
        seed = 4;
        run_copy(16, 40, 40, 1'b0, "R6");
        check(nrd == 0, "R6", "destination reads for aligned whole bytes", nrd, 0);
        check(nwr == 5, "R7", "writes for five aligned bytes", nwr, 5);
        check(last_wr - first_wr == 4, "R7", "aligned writes back to back", last_wr - first_wr, 4);
        seed = 5;
        run_copy(8, 80, 44, 1'b0, "R6");
        check(nrd == 1, "R6", "single tail read for aligned partial end", nrd, 1);
    endtask

    task automatic test_phases;
        seed = 1; run_copy(3, 10, 4, 1'b0, "R2");
        seed = 2; run_copy(5, 13, 37, 1'b0, "R2");
        seed = 3; run_copy(0, 7, 9, 1'b0, "R2");
        seed = 6; run_copy(7, 0, 20, 1'b0, "R1");
        seed = 7; run_copy(11, 3, 1, 1'b0, "R2");
        seed = 8; run_copy(2, 2, 64, 1'b0, "R2");
        seed = 10; run_copy(1, 606, 100, 1'b0, "R2");
        seed = 11; run_copy(6, 1, 7, 1'b0, "R3");
    endtask

    task automatic test_busy_start;
        seed = 12;
        run_copy(9, 203, 90, 1'b1, "R9");
        check(ndone == 1, "R9", "done pulses with start during busy", ndone, 1);
        check(busy == 1'b0, "R9", "engine idle after ignored start", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_zero_count();
        test_aligned();
        test_phases();
        test_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule